// File: doc/BRIEF.md
# Deskew Training Pattern Generator

The block sits on the transmit side of a 7:1 serialized link, just ahead of the serializer. It produces one 7-bit clock-lane symbol and one 7-bit symbol for each of the data lanes on every cycle. When a training run is requested, it drives fixed patterns that let the far-end receiver calibrate its per-lane sampling strobes. When no run is active, the clock lane carries the normal framing symbol and the data lanes pass the caller's payload through.

Two training options exist, and the option input chooses between them. With the option high, the data lanes toggle between all ones and all zeros on alternate cycles. With the option low, the data lanes repeat a fixed clock-like symbol. A variant input chooses which of two clock-lane shapes is used within the selected option. Both inputs are captured when the run starts.

A run lasts exactly the programmed lock delay plus a fixed minimum of `TRAIN_MIN` cycles (4096 by default). This covers the receiver's PLL lock time and its calibration window. Asserting start again during a run restarts the full duration.

Top module: `dsk_train_gen`

## Requirements
- R1: While `rst_ni` is low and after release with no start, `busy_o` and `done_o` are 0 and the outputs are in normal mode.
- R2: When not training, `clk_sym_o` is 7'b1100011 and every lane of `data_sym_o` equals the same lane of `data_i` in the same cycle (lane k at bits 7k+6..7k).
- R3: A start sampled at a clock edge makes `busy_o` high for exactly `lock_dly_i + TRAIN_MIN` cycles, from the cycle after that edge.
- R4: In training with option high, `clk_sym_o` is 7'b1111000 when variant is 0 and 7'b1110000 when variant is 1. Symbols are written with bit 6 sent first.
- R5: In training with option high, all data lanes are 7'b1111111 in the first training cycle and then alternate between 7'b0000000 and 7'b1111111 on each cycle.
- R6: In training with option low, `clk_sym_o` is 7'b1111100 when variant is 0 and 7'b1100000 when variant is 1.
- R7: In training with option low, every data lane carries 7'b1111000 (variant 0) or 7'b1110000 (variant 1) on every cycle.
- R8: `done_o` rises in the first cycle after a run ends and stays high until the next start. It is 0 throughout a run.
- R9: A start during a run reloads the full duration and restarts the data alternation with all ones.
- R10: Option and variant are captured at start. Changes to them during a run do not affect the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Symbol clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start or restart a training run |
| opt_i | input | 1 | Training option select |
| alt_i | input | 1 | Clock-lane pattern variant select |
| lock_dly_i | input | LOCK_W | Lock delay in cycles, added to TRAIN_MIN |
| data_i | input | 7*LANES | Normal payload symbols |
| clk_sym_o | output | 7 | Clock-lane symbol |
| data_sym_o | output | 7*LANES | Data-lane symbols |
| busy_o | output | 1 | Training run in progress |
| done_o | output | 1 | Last run completed |

## Verification
If the duration counter holds a wrong value, the first sign at the ports is `busy_o` dropping early or late. That edge is checked in the exact cycle it is expected, so a count that is off by one shows up at the end of every run. A wrong alternation phase, or a wrong captured option, inverts or changes the data-lane symbols from the first training cycle onward, and every cycle of every run is compared. A mode register that follows the live inputs instead of the captured values changes the symbols in the cycle right after those inputs are flipped mid-run.

// File: rtl/dsk_pkg.sv
package dsk_pkg;
  localparam int SYM_W = 7;
  typedef logic [SYM_W-1:0] sym_t;

  typedef struct packed {
    logic opt;
    logic alt;
  } train_cfg_t;

  localparam sym_t NORM_CLK_SYM = 7'b1100011;
  localparam sym_t OPT_HI_CLK0  = 7'b1111000;
  localparam sym_t OPT_HI_CLK1  = 7'b1110000;
  localparam sym_t OPT_LO_CLK0  = 7'b1111100;
  localparam sym_t OPT_LO_CLK1  = 7'b1100000;
  localparam sym_t OPT_LO_DAT0  = 7'b1111000;
  localparam sym_t OPT_LO_DAT1  = 7'b1110000;
endpackage

// File: rtl/dsk_train_timer.sv
module dsk_train_timer #(
  parameter int LOCK_W    = 16,
  parameter int TRAIN_MIN = 4096
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [LOCK_W-1:0] lock_dly_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              phase_o
);
  localparam int MIN_W = $clog2(TRAIN_MIN + 1);
  localparam int CNT_W = ((LOCK_W > MIN_W) ? LOCK_W : MIN_W) + 1;

  logic [CNT_W-1:0] cnt_q;
  logic             phase_q;
  logic             done_q;
  logic [CNT_W-1:0] load_val;

  assign load_val = CNT_W'(lock_dly_i) + CNT_W'(TRAIN_MIN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
      done_q  <= 1'b0;
    end else if (start_i) begin
      cnt_q   <= load_val;
      phase_q <= 1'b0;
      done_q  <= 1'b0;
    end else if (cnt_q != '0) begin
      cnt_q   <= cnt_q - 1'b1;
      phase_q <= ~phase_q;
      if (cnt_q == CNT_W'(1)) done_q <= 1'b1;
    end
  end

  assign busy_o  = (cnt_q != '0);
  assign done_o  = done_q;
  assign phase_o = phase_q;
endmodule

// File: rtl/dsk_pattern_sel.sv
module dsk_pattern_sel
  import dsk_pkg::*;
(
  input  train_cfg_t cfg_i,
  input  logic       phase_i,
  output sym_t       clk_sym_o,
  output sym_t       lane_sym_o
);
  always_comb begin
    if (cfg_i.opt) begin
      clk_sym_o  = cfg_i.alt ? OPT_HI_CLK1 : OPT_HI_CLK0;
      // phase 0 is the first training cycle: all ones
      lane_sym_o = phase_i ? '0 : '1;
    end else begin
      clk_sym_o  = cfg_i.alt ? OPT_LO_CLK1 : OPT_LO_CLK0;
      lane_sym_o = cfg_i.alt ? OPT_LO_DAT1 : OPT_LO_DAT0;
    end
  end
endmodule

// File: rtl/dsk_lane_mux.sv
module dsk_lane_mux
  import dsk_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic                   train_i,
  input  sym_t                   lane_sym_i,
  input  logic [SYM_W*LANES-1:0] data_i,
  output logic [SYM_W*LANES-1:0] data_sym_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign data_sym_o[g*SYM_W +: SYM_W] =
      train_i ? lane_sym_i : data_i[g*SYM_W +: SYM_W];
  end
endmodule

// File: rtl/dsk_train_gen.sv
module dsk_train_gen
  import dsk_pkg::*;
#(
  parameter int LANES     = 8,
  parameter int LOCK_W    = 16,
  parameter int TRAIN_MIN = 4096
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic                   opt_i,
  input  logic                   alt_i,
  input  logic [LOCK_W-1:0]      lock_dly_i,
  input  logic [SYM_W*LANES-1:0] data_i,
  output logic [SYM_W-1:0]       clk_sym_o,
  output logic [SYM_W*LANES-1:0] data_sym_o,
  output logic                   busy_o,
  output logic                   done_o
);
  train_cfg_t cfg_q;
  logic       busy;
  logic       phase;
  sym_t       trn_clk_sym;
  sym_t       trn_lane_sym;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cfg_q <= '0;
    else if (start_i) cfg_q <= '{opt: opt_i, alt: alt_i};
  end

  dsk_train_timer #(
    .LOCK_W   (LOCK_W),
    .TRAIN_MIN(TRAIN_MIN)
  ) timer_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .lock_dly_i(lock_dly_i),
    .busy_o    (busy),
    .done_o    (done_o),
    .phase_o   (phase)
  );

  dsk_pattern_sel pat_i (
    .cfg_i     (cfg_q),
    .phase_i   (phase),
    .clk_sym_o (trn_clk_sym),
    .lane_sym_o(trn_lane_sym)
  );

  dsk_lane_mux #(.LANES(LANES)) mux_i (
    .train_i   (busy),
    .lane_sym_i(trn_lane_sym),
    .data_i    (data_i),
    .data_sym_o(data_sym_o)
  );

  assign clk_sym_o = busy ? trn_clk_sym : NORM_CLK_SYM;
  assign busy_o    = busy;
endmodule

// File: rtl/dsk_train_chk.sv
module dsk_train_chk #(
  parameter int LANES = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               start_i,
  input logic               busy_o,
  input logic               done_o,
  input logic               opt_q,
  input logic [6:0]         clk_sym_o,
  input logic [7*LANES-1:0] data_sym_o,
  input logic [7*LANES-1:0] data_i
);
  assert_pass_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> data_sym_o == data_i);

  assert_start_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o);

  assert_toggle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && opt_q && $past(busy_o) && !$past(start_i)
      |-> data_sym_o[6:0] != $past(data_sym_o[6:0]));

  assert_lanes_equal_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> data_sym_o == {LANES{data_sym_o[6:0]}});

  assert_done_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !done_o);

  assert_done_end_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  assert_clk_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !start_i |=> !busy_o || $stable(clk_sym_o));
endmodule

bind dsk_train_gen dsk_train_chk #(.LANES(LANES)) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .opt_q     (cfg_q.opt),
  .clk_sym_o (clk_sym_o),
  .data_sym_o(data_sym_o),
  .data_i    (data_i)
);

// File: tb/dsk_train_gen_tb_top.sv
module dsk_train_gen_tb_top;
  localparam int LANES  = 8;
  localparam int LOCK_W = 16;
  localparam int TMIN   = 4096;
  localparam int DW     = 7 * LANES;
  localparam logic [6:0] NORM = 7'b1100011;

  typedef struct packed {
    logic       opt;
    logic       alt;
    logic [7:0] lock;
    logic [6:0] clk;
    logic [6:0] d_odd;   // training cycles 1,3,5...
    logic [6:0] d_even;  // training cycles 2,4,6...
  } vec_t;

  localparam vec_t VEC [4] = '{
    '{1'b1, 1'b0, 8'd0,  7'b1111000, 7'b1111111, 7'b0000000},
    '{1'b1, 1'b1, 8'd3,  7'b1110000, 7'b1111111, 7'b0000000},
    '{1'b0, 1'b0, 8'd7,  7'b1111100, 7'b1111000, 7'b1111000},
    '{1'b0, 1'b1, 8'd12, 7'b1100000, 7'b1110000, 7'b1110000}
  };

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              start_i = 1'b0;
  logic              opt_i = 1'b0;
  logic              alt_i = 1'b0;
  logic [LOCK_W-1:0] lock_dly_i = '0;
  logic [DW-1:0]     data_i = 56'h0123456789abcd;
  logic [6:0]        clk_sym_o;
  logic [DW-1:0]     data_sym_o;
  logic              busy_o;
  logic              done_o;

  int total = 0;
  int bad   = 0;
  bit fin   = 1'b0;

  always #10 clk_i = ~clk_i;

  dsk_train_gen #(.LANES(LANES), .LOCK_W(LOCK_W), .TRAIN_MIN(TMIN)) dut_i (
    .clk_i, .rst_ni, .start_i, .opt_i, .alt_i, .lock_dly_i, .data_i,
    .clk_sym_o, .data_sym_o, .busy_o, .done_o
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    #1;
  endtask

  task automatic chk_normal(input string req);
    chk(busy_o == 1'b0, req, 64'(busy_o), 64'd0);
    chk(clk_sym_o == NORM, req, 64'(clk_sym_o), 64'(NORM));
    chk(data_sym_o == data_i, req, 64'(data_sym_o), 64'(data_i));
  endtask

  task automatic run_vec(input vec_t v);
    int n;
    n = int'(v.lock) + TMIN;
    opt_i = v.opt; alt_i = v.alt; lock_dly_i = LOCK_W'(v.lock); start_i = 1'b1;
    step();
    start_i = 1'b0;
    opt_i = ~v.opt; alt_i = ~v.alt;  // R10: flipped after capture
    for (int i = 1; i <= n; i++) begin
      logic [6:0] ed;
      ed = (i % 2 == 1) ? v.d_odd : v.d_even;
      chk(busy_o == 1'b1, "R3 busy", 64'(busy_o), 64'd1);
      chk(done_o == 1'b0, "R8 done low", 64'(done_o), 64'd0);
      chk(clk_sym_o == v.clk, v.opt ? "R4 R10 clk" : "R6 R10 clk", 64'(clk_sym_o), 64'(v.clk));
      chk(data_sym_o == {LANES{ed}}, v.opt ? "R5 R10 data" : "R7 R10 data",
          64'(data_sym_o), 64'({LANES{ed}}));
      step();
    end
    chk(done_o == 1'b1, "R8 done high", 64'(done_o), 64'd1);
    chk_normal("R3 R2 end");
  endtask

  initial begin
    repeat (3) step();
    chk(done_o == 1'b0, "R1 done", 64'(done_o), 64'd0);
    chk_normal("R1 in reset");
    rst_ni = 1'b1;
    repeat (3) step();
    chk(done_o == 1'b0, "R1 done", 64'(done_o), 64'd0);
    chk_normal("R1 after reset");
    data_i = 56'hfedcba98765432;
    #1;
    chk_normal("R2 pass");

    for (int k = 0; k < 4; k++) run_vec(VEC[k]);

    // R8: done holds, then clears on start
    repeat (5) step();
    chk(done_o == 1'b1, "R8 sticky", 64'(done_o), 64'd1);

    // R9: restart mid run
    opt_i = 1'b1; alt_i = 1'b0; lock_dly_i = 16'd2; start_i = 1'b1;
    step();
    start_i = 1'b0;
    chk(done_o == 1'b0, "R8 cleared", 64'(done_o), 64'd0);
    repeat (9) step();
    start_i = 1'b1;
    step();
    start_i = 1'b0;
    chk(data_sym_o == {LANES{7'b1111111}}, "R9 phase", 64'(data_sym_o), 64'({LANES{7'b1111111}}));
    begin
      int cnt;
      cnt = 0;
      while (busy_o && cnt < 10000) begin
        cnt++;
        step();
      end
      chk(cnt == 2 + TMIN, "R9 length", 64'(cnt), 64'(2 + TMIN));
    end
    chk(done_o == 1'b1, "R8 R9 done", 64'(done_o), 64'd1);
    chk_normal("R2 after restart");

    fin = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!fin) begin
      total++;
      bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule